// File: doc/BRIEF.md
# SCSI Controller Register and Interrupt Front End

This block is the byte-wide, memory-mapped register face of a simple SCSI bus controller. A host reaches 16 byte addresses. A read and a write at the same address can reach different registers: at one address a read returns status and a write sets the target ID. The block decodes the command byte, keeps the status, interrupt-cause and sequence-step registers, and drives one level-sensitive interrupt line. It does not model bus phases, targets or data movement. Commands that need the bus are passed on as a one-cycle request to an external sequencer. The sequencer reports completion with a one-cycle pulse that carries the resulting bus phase.

Reading the interrupt-cause register is the host's acknowledge. The read returns the cause as it stood before the read. In the same access the cause is cleared, the terminal-count status bit is cleared, the sequence step is forced to the command-done value and the interrupt line falls. Commands are recognised from bits 6:0 of the byte written to the command register. Bit 7 of that byte requests DMA mode, which reloads the working transfer count from the last values the host wrote.

Top module: `scsi_regif`

## Requirements
- R1: After rst_n or a chip-reset command (opcode 0x02), the register reads are as follows: status 0x00, cause 0x00, sequence step 0, command register 0x00, working count 0x00, config1 0x07 and count-high (address 0xE) 0x04. The irq output is low.
- R2: A write to a count address (0x0 low, 0x1 mid) goes to a shadow register, and a read of that address returns the working count. A write to 0x4 sets the target ID (bits 2:0) and does not change the status byte that reads of 0x4 return.
- R3: A command byte with bit 7 set copies both shadow counts into the working counts. A command byte with bit 7 clear leaves the working counts unchanged.
- R4: A write to either count address clears status bit 4, the terminal-count bit.
- R5: A read of the cause register (0x5) returns the value it held before the read. After that read, the cause is 0x00, status bit 4 is 0, the sequence step (0x6) is 4 and irq is low.
- R6: Status bit 7 always equals the irq output. irq rises only in the cycle after a command write or a sequencer completion pulse.
- R7: Bus reset (opcode 0x03) sets the cause to 0x80. It raises irq only when config1 (0x8) bit 6 is clear.
- R8: Flush (0x01) sets the cause to 0x08 and the step to 0, and leaves irq unchanged. Pad (0x18) sets status bits 6:0 to 0x10, the cause to 0x08 and the step to 0, without raising irq.
- R9: Select (0x41, 0x42, 0x43) to a target whose ID bit in tgt_present is 0 gives status 0x80, cause 0x20 (disconnect), step 0 and irq high. Select to a present target, or transfer (0x10), pulses cmd_go for one cycle with the opcode on cmd_op and bit 7 on cmd_dma.
- R10: A seq_done pulse sets status bits 6:0 to 0x10 OR seq_phase, the cause to 0x18, the step to 4, and raises irq.
- R11: Message accepted (0x12) sets the cause to 0x20 and the step to 0, and raises irq. Complete sequence (0x11) sets the status phase bits 2:0 to 7 (message in) and the cause to 0x08, and raises irq.
- R12: Enable selection (0x44) clears the cause. Set-ATN (0x1A), no-op (0x00) and any unlisted opcode change nothing except the command register (0x3), which always reads back the last command byte.
- R13: Writes to 0x2, 0x6, 0x7, 0x9, 0xA, 0xD and 0xF are ignored. Reads of 0x2, 0x7, 0x9, 0xA, 0xD and 0xF return 0x00. Config2 (0xB) and config3 (0xC) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational, pre-side-effect |
| tgt_present | input | 8 | One bit per target ID, 1 = target present |
| seq_done | input | 1 | One-cycle completion pulse from the sequencer |
| seq_phase | input | 3 | Bus phase reported with seq_done |
| cmd_go | output | 1 | One-cycle request to the sequencer |
| cmd_op | output | 7 | Opcode of the request |
| cmd_dma | output | 1 | DMA bit of the request |
| irq | output | 1 | Level interrupt, mirrors status bit 7 |

## Verification
On every cycle the assertions check the following: the irq output against the status bit 7 the host would read; the side effects of acknowledging a cause read; the reset defaults after a chip-reset command; the count reload on DMA commands; the masking of bus-reset interrupts by config1 bit 6; that irq only rises after a command write or a completion pulse. Several behaviours can only be seen in the bench's ordered scenarios. These are the split between read and write registers, the value returned by a read before its clear, commands that must leave state alone, and the handshake between a present-target select and the sequencer's completion.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;

  localparam int unsigned DW = 8;
  localparam int unsigned AW = 4;

  // register addresses (read view / write view where they differ)
  localparam logic [AW-1:0] A_CNT_LO  = 4'h0;
  localparam logic [AW-1:0] A_CNT_MID = 4'h1;
  localparam logic [AW-1:0] A_CMD     = 4'h3;
  localparam logic [AW-1:0] A_STAT_ID = 4'h4;
  localparam logic [AW-1:0] A_CAUSE   = 4'h5;
  localparam logic [AW-1:0] A_STEP    = 4'h6;
  localparam logic [AW-1:0] A_CFG1    = 4'h8;
  localparam logic [AW-1:0] A_CFG2    = 4'hB;
  localparam logic [AW-1:0] A_CFG3    = 4'hC;
  localparam logic [AW-1:0] A_CNT_HI  = 4'hE;

  // interrupt cause codes
  localparam logic [DW-1:0] CAUSE_FUNC_DONE = 8'h08;
  localparam logic [DW-1:0] CAUSE_BUS_SVC   = 8'h10;
  localparam logic [DW-1:0] CAUSE_DISC      = 8'h20;
  localparam logic [DW-1:0] CAUSE_BUS_RST   = 8'h80;

  // status bit positions (bit 7 is the interrupt flag, kept in the irq unit)
  localparam int unsigned ST_TC_BIT = 4;
  localparam logic [2:0]  PH_MSG_IN = 3'd7;

  typedef enum logic [3:0] {
    OPK_NOP, OPK_FLUSH, OPK_CHIPRST, OPK_BUSRST, OPK_XFER, OPK_CPLSEQ,
    OPK_MSGOK, OPK_PAD, OPK_ATN, OPK_SEL, OPK_ENSEL, OPK_UNKNOWN
  } op_kind_e;

  function automatic op_kind_e classify_op(input logic [6:0] op);
    case (op)
      7'h00:               return OPK_NOP;
      7'h01:               return OPK_FLUSH;
      7'h02:               return OPK_CHIPRST;
      7'h03:               return OPK_BUSRST;
      7'h10:               return OPK_XFER;
      7'h11:               return OPK_CPLSEQ;
      7'h12:               return OPK_MSGOK;
      7'h18:               return OPK_PAD;
      7'h1A:               return OPK_ATN;
      7'h41, 7'h42, 7'h43: return OPK_SEL;
      7'h44:               return OPK_ENSEL;
      default:             return OPK_UNKNOWN;
    endcase
  endfunction

endpackage

// File: rtl/scsi_regif_cmd_dec.sv
module scsi_regif_cmd_dec
  import scsi_regif_pkg::*;
#(
  parameter int unsigned ID_W = 3,
  localparam int unsigned NTGT = 1 << ID_W
) (
  input  logic [DW-1:0]   cmd_byte,
  input  logic [ID_W-1:0] target_id,
  input  logic [NTGT-1:0] tgt_present,
  output op_kind_e        kind,
  output logic            dma_req,
  output logic            tgt_ok
);

  assign kind    = classify_op(cmd_byte[6:0]);
  assign dma_req = cmd_byte[7];
  assign tgt_ok  = tgt_present[target_id];

endmodule

// File: rtl/scsi_regif_irq.sv
module scsi_regif_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq,
  output logic irq_rise,
  output logic irq_fall
);

  logic irq_q;

  // a set request wins over a clear in the same cycle
  assign irq_rise = set_req && !irq_q;
  assign irq_fall = clr_req && !set_req && irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (irq_rise) irq_q <= 1'b1;
    else if (irq_fall) irq_q <= 1'b0;
  end

  assign irq = irq_q;

endmodule

// File: rtl/scsi_regif.sv
module scsi_regif
  import scsi_regif_pkg::*;
#(
  parameter int unsigned ID_W       = 3,
  parameter logic [7:0]  CFG1_RESET = 8'h07,
  parameter logic [7:0]  CHIP_ID    = 8'h04,
  localparam int unsigned NTGT      = 1 << ID_W,
  localparam int unsigned STEP_W    = 3,
  localparam logic [STEP_W-1:0] STEP_CMD_DONE = STEP_W'(4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NTGT-1:0] tgt_present,
  input  logic            seq_done,
  input  logic [2:0]      seq_phase,
  output logic            cmd_go,
  output logic [6:0]      cmd_op,
  output logic            cmd_dma,
  output logic            irq
);

  // register state
  logic [DW-1:0]     sh_lo_q, sh_mid_q;
  logic [DW-1:0]     cnt_lo_q, cnt_mid_q, cnt_hi_q;
  logic [DW-1:0]     cmd_q, cause_q, cfg1_q, cfg2_q, cfg3_q;
  logic [ID_W-1:0]   busid_q;
  logic [6:0]        stat_q;
  logic [STEP_W-1:0] step_q;
  logic              go_q, go_dma_q;
  logic [6:0]        go_op_q;

  // named events
  logic     wr_cmd, rd_cause, soft_rst, raise_evt, clear_evt;
  logic     dec_dma, dec_tgt_ok, sel_miss, send_seq;
  logic     irq_rise, irq_fall;
  op_kind_e dec_kind;

  scsi_regif_cmd_dec #(.ID_W(ID_W)) u_dec (
    .cmd_byte    (wdata),
    .target_id   (busid_q),
    .tgt_present (tgt_present),
    .kind        (dec_kind),
    .dma_req     (dec_dma),
    .tgt_ok      (dec_tgt_ok)
  );

  assign wr_cmd   = wr_en && (addr == A_CMD);
  assign rd_cause = rd_en && (addr == A_CAUSE);
  assign soft_rst = wr_cmd && (dec_kind == OPK_CHIPRST);
  assign sel_miss = wr_cmd && (dec_kind == OPK_SEL) && !dec_tgt_ok;
  assign send_seq = wr_cmd && ((dec_kind == OPK_XFER) ||
                               ((dec_kind == OPK_SEL) && dec_tgt_ok));

  assign raise_evt = seq_done || sel_miss ||
                     (wr_cmd && ((dec_kind == OPK_MSGOK) || (dec_kind == OPK_CPLSEQ) ||
                                 ((dec_kind == OPK_BUSRST) && !cfg1_q[6])));
  assign clear_evt = rd_cause || soft_rst;

  scsi_regif_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (raise_evt),
    .clr_req  (clear_evt),
    .irq      (irq),
    .irq_rise (irq_rise),
    .irq_fall (irq_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_lo_q <= '0; sh_mid_q <= '0;
      cnt_lo_q <= '0; cnt_mid_q <= '0; cnt_hi_q <= CHIP_ID;
      cmd_q <= '0; cause_q <= '0; cfg1_q <= CFG1_RESET;
      cfg2_q <= '0; cfg3_q <= '0; busid_q <= '0;
      stat_q <= '0; step_q <= '0;
    end else if (soft_rst) begin
      // R1: chip reset clears everything, then loads the fixed codes
      sh_lo_q <= '0; sh_mid_q <= '0;
      cnt_lo_q <= '0; cnt_mid_q <= '0; cnt_hi_q <= CHIP_ID;
      cmd_q <= '0; cause_q <= '0; cfg1_q <= CFG1_RESET;
      cfg2_q <= '0; cfg3_q <= '0; busid_q <= '0;
      stat_q <= '0; step_q <= '0;
    end else begin
      // R5: acknowledge side effects of a cause read
      if (rd_cause) begin
        cause_q          <= '0;
        stat_q[ST_TC_BIT] <= 1'b0;
        step_q           <= STEP_CMD_DONE;
      end
      if (wr_en) begin
        case (addr)
          A_CNT_LO:  begin sh_lo_q  <= wdata; stat_q[ST_TC_BIT] <= 1'b0; end  // R4
          A_CNT_MID: begin sh_mid_q <= wdata; stat_q[ST_TC_BIT] <= 1'b0; end  // R4
          A_STAT_ID: busid_q  <= wdata[ID_W-1:0];                             // R2
          A_CFG1:    cfg1_q   <= wdata;
          A_CFG2:    cfg2_q   <= wdata;
          A_CFG3:    cfg3_q   <= wdata;
          A_CNT_HI:  cnt_hi_q <= wdata;
          A_CMD: begin
            cmd_q <= wdata;
            if (dec_dma) begin          // R3: reload working count
              cnt_lo_q  <= sh_lo_q;
              cnt_mid_q <= sh_mid_q;
            end
            case (dec_kind)
              OPK_FLUSH: begin cause_q <= CAUSE_FUNC_DONE; step_q <= '0; end   // R8
              OPK_BUSRST: cause_q <= CAUSE_BUS_RST;                             // R7
              OPK_XFER: if (dec_dma) stat_q[ST_TC_BIT] <= 1'b0;
              OPK_CPLSEQ: begin                                                 // R11
                cause_q     <= CAUSE_FUNC_DONE;
                stat_q[2:0] <= PH_MSG_IN;
              end
              OPK_MSGOK: begin cause_q <= CAUSE_DISC; step_q <= '0; end        // R11
              OPK_PAD: begin                                                    // R8
                stat_q  <= 7'h10;
                cause_q <= CAUSE_FUNC_DONE;
                step_q  <= '0;
              end
              OPK_SEL: if (!dec_tgt_ok) begin                                   // R9
                stat_q  <= '0;
                cause_q <= CAUSE_DISC;
                step_q  <= '0;
              end
              OPK_ENSEL: cause_q <= '0;                                         // R12
              default: ;
            endcase
          end
          default: ;                                                            // R13
        endcase
      end
      // R10: sequencer completion
      if (seq_done) begin
        stat_q  <= {4'b0010, seq_phase};
        cause_q <= CAUSE_BUS_SVC | CAUSE_FUNC_DONE;
        step_q  <= STEP_CMD_DONE;
      end
    end
  end

  // request to the sequencer (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q <= 1'b0; go_op_q <= '0; go_dma_q <= 1'b0;
    end else begin
      go_q <= send_seq;
      if (send_seq) begin
        go_op_q  <= wdata[6:0];
        go_dma_q <= dec_dma;
      end
    end
  end

  assign cmd_go  = go_q;
  assign cmd_op  = go_op_q;
  assign cmd_dma = go_dma_q;

  // read view; returns state before this access's side effects
  always_comb begin
    case (addr)
      A_CNT_LO:  rdata = cnt_lo_q;
      A_CNT_MID: rdata = cnt_mid_q;
      A_CMD:     rdata = cmd_q;
      A_STAT_ID: rdata = {irq, stat_q};    // R6
      A_CAUSE:   rdata = cause_q;
      A_STEP:    rdata = DW'(step_q);
      A_CFG1:    rdata = cfg1_q;
      A_CFG2:    rdata = cfg2_q;
      A_CFG3:    rdata = cfg3_q;
      A_CNT_HI:  rdata = cnt_hi_q;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/scsi_regif_chk.sv
module scsi_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       irq,
  input logic       seq_done,
  input logic [7:0] cause_q,
  input logic [2:0] step_q,
  input logic [7:0] cfg1_q,
  input logic [7:0] cnt_hi_q,
  input logic [7:0] cnt_lo_q,
  input logic [7:0] sh_lo_q,
  input logic       stat_tc
);

  p_chiprst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h3 && wdata[6:0] == 7'h02) |=>
      (cfg1_q == 8'h07 && cnt_hi_q == 8'h04 && !irq && cause_q == 8'h00));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h3 && wdata[7] && wdata[6:0] != 7'h02) |=>
      (cnt_lo_q == $past(sh_lo_q)));

  p_cntwr_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 4'h0 || addr == 4'h1) && !seq_done) |=> !stat_tc);

  p_cause_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'h5 && !wr_en && !seq_done) |=>
      (cause_q == 8'h00 && step_q == 3'd4 && !irq && !stat_tc));

  p_irq_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'h4) |-> (rdata[7] == irq));

  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_en || seq_done));

  p_busrst_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h3 && wdata[6:0] == 7'h03 && cfg1_q[6] &&
     !irq && !seq_done) |=> !irq);

  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (irq && cause_q == 8'h18 && step_q == 3'd4 && stat_tc));

endmodule

bind scsi_regif scsi_regif_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq      (irq),
  .seq_done (seq_done),
  .cause_q  (cause_q),
  .step_q   (step_q),
  .cfg1_q   (cfg1_q),
  .cnt_hi_q (cnt_hi_q),
  .cnt_lo_q (cnt_lo_q),
  .sh_lo_q  (sh_lo_q),
  .stat_tc  (stat_q[4])
);

// File: tb/scsi_regif_tb.sv
module scsi_regif_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] tgt_present = 8'b0000_0101;   // IDs 0 and 2 present
  logic       seq_done = 1'b0;
  logic [2:0] seq_phase = '0;
  logic       cmd_go, cmd_dma, irq;
  logic [6:0] cmd_op;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  scsi_regif u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tgt_present(tgt_present),
    .seq_done(seq_done), .seq_phase(seq_phase), .cmd_go(cmd_go),
    .cmd_op(cmd_op), .cmd_dma(cmd_dma), .irq(irq)
  );

  // entry: {is_read, requirement, address, write data or expected read}
  localparam int NV = 83;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1,4'd1,4'h8,8'h07}, {1'b1,4'd1,4'hE,8'h04}, {1'b1,4'd1,4'h4,8'h00},
    {1'b1,4'd1,4'h5,8'h00},
    {1'b0,4'd2,4'h0,8'h34}, {1'b1,4'd2,4'h0,8'h00},
    {1'b0,4'd3,4'h1,8'h12}, {1'b0,4'd3,4'h3,8'h80}, {1'b1,4'd3,4'h0,8'h34},
    {1'b1,4'd3,4'h1,8'h12}, {1'b0,4'd3,4'h0,8'h55}, {1'b0,4'd3,4'h3,8'h00},
    {1'b1,4'd3,4'h0,8'h34},
    {1'b0,4'd2,4'h4,8'h03}, {1'b1,4'd2,4'h4,8'h00},
    {1'b0,4'd9,4'h3,8'h41}, {1'b1,4'd9,4'h4,8'h80}, {1'b1,4'd5,4'h5,8'h20},
    {1'b1,4'd5,4'h5,8'h00}, {1'b1,4'd5,4'h4,8'h00}, {1'b1,4'd5,4'h6,8'h04},
    {1'b0,4'd8,4'h3,8'h01}, {1'b1,4'd8,4'h4,8'h00}, {1'b1,4'd8,4'h6,8'h00},
    {1'b1,4'd8,4'h5,8'h08},
    {1'b0,4'd7,4'h8,8'h47}, {1'b0,4'd7,4'h3,8'h03}, {1'b1,4'd7,4'h4,8'h00},
    {1'b1,4'd7,4'h5,8'h80}, {1'b0,4'd7,4'h8,8'h07}, {1'b0,4'd7,4'h3,8'h03},
    {1'b1,4'd7,4'h4,8'h80}, {1'b1,4'd7,4'h5,8'h80},
    {1'b0,4'd8,4'h3,8'h18}, {1'b1,4'd8,4'h4,8'h10}, {1'b1,4'd8,4'h6,8'h00},
    {1'b1,4'd8,4'h5,8'h08}, {1'b1,4'd5,4'h4,8'h00},
    {1'b0,4'd11,4'h3,8'h12}, {1'b1,4'd11,4'h4,8'h80}, {1'b1,4'd11,4'h6,8'h00},
    {1'b1,4'd11,4'h5,8'h20}, {1'b0,4'd11,4'h3,8'h11}, {1'b1,4'd11,4'h4,8'h87},
    {1'b1,4'd11,4'h5,8'h08}, {1'b1,4'd11,4'h4,8'h07},
    {1'b0,4'd12,4'h3,8'h1A}, {1'b1,4'd12,4'h4,8'h07}, {1'b1,4'd12,4'h3,8'h1A},
    {1'b0,4'd12,4'h3,8'h7F}, {1'b1,4'd12,4'h3,8'h7F}, {1'b1,4'd12,4'h4,8'h07},
    {1'b0,4'd12,4'h3,8'h01}, {1'b0,4'd12,4'h3,8'h44}, {1'b1,4'd12,4'h5,8'h00},
    {1'b0,4'd13,4'h2,8'hAA}, {1'b1,4'd13,4'h2,8'h00}, {1'b0,4'd13,4'hD,8'h55},
    {1'b1,4'd13,4'hD,8'h00}, {1'b0,4'd13,4'h9,8'hFF}, {1'b1,4'd13,4'h9,8'h00},
    {1'b0,4'd13,4'h6,8'h33}, {1'b1,4'd13,4'h6,8'h04}, {1'b0,4'd13,4'h7,8'hFF},
    {1'b1,4'd13,4'h7,8'h00}, {1'b0,4'd13,4'hB,8'h5A}, {1'b1,4'd13,4'hB,8'h5A},
    {1'b0,4'd13,4'hC,8'hC3}, {1'b1,4'd13,4'hC,8'hC3},
    {1'b0,4'd8,4'h3,8'h18}, {1'b1,4'd4,4'h4,8'h10}, {1'b0,4'd4,4'h1,8'h01},
    {1'b1,4'd4,4'h4,8'h00}, {1'b1,4'd8,4'h5,8'h08},
    {1'b0,4'd1,4'hE,8'h99}, {1'b1,4'd1,4'hE,8'h99}, {1'b0,4'd1,4'h8,8'h4F},
    {1'b0,4'd1,4'h3,8'h02}, {1'b1,4'd1,4'h8,8'h07}, {1'b1,4'd1,4'hE,8'h04},
    {1'b1,4'd1,4'h3,8'h00}, {1'b1,4'd1,4'h0,8'h00}, {1'b1,4'd1,4'h4,8'h00}
  };

  task automatic check(input int req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input int req);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1;
    check(req, $sformatf("read addr 0x%0h", a), rdata, exp);
    if (a == 4'h4) check(6, "irq vs status bit 7 (R6)", irq, exp[7]);
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic pulse_done(input logic [2:0] ph);
    @(negedge clk);
    seq_done = 1'b1; seq_phase = ph;
    @(posedge clk);
    #1 seq_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1, "irq in reset (R1)", irq, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) rd(VEC[i][7:0] == 8'h00 ? VEC[i][11:8] : VEC[i][11:8], VEC[i][7:0], int'(VEC[i][15:12]));
      else            wr(VEC[i][11:8], VEC[i][7:0]);
    end

    // R9: select to a present target goes to the sequencer
    wr(4'h4, 8'h02);
    wr(4'h3, 8'h42);
    check(9, "cmd_go after present select (R9)", cmd_go, 1);
    check(9, "cmd_op (R9)", cmd_op, 7'h42);
    check(9, "cmd_dma (R9)", cmd_dma, 0);
    check(9, "no irq on present select (R9)", irq, 0);
    @(posedge clk); #1;
    check(9, "cmd_go one cycle (R9)", cmd_go, 0);

    // R10: completion from the sequencer, phase command (2)
    pulse_done(3'd2);
    check(10, "irq after completion (R10)", irq, 1);
    rd(4'h4, 8'h92, 10);
    rd(4'h6, 8'h04, 10);
    rd(4'h5, 8'h18, 10);
    rd(4'h4, 8'h02, 5);

    // R3/R9: DMA transfer command reloads count and requests sequencer
    wr(4'h0, 8'h20);
    wr(4'h3, 8'h90);
    check(9, "cmd_go on DMA transfer (R9)", cmd_go, 1);
    check(9, "cmd_op transfer (R9)", cmd_op, 7'h10);
    check(3, "cmd_dma on DMA transfer (R3)", cmd_dma, 1);
    rd(4'h0, 8'h20, 3);

    // R1: asynchronous reset mid-run
    wr(4'h3, 8'h12);
    check(11, "irq after message accepted (R11)", irq, 1);
    @(negedge clk); rst_n = 1'b0;
    #1 check(1, "irq drops on reset (R1)", irq, 0);
    @(negedge clk); rst_n = 1'b1;
    rd(4'h5, 8'h00, 1);
    rd(4'h8, 8'h07, 1);
    rd(4'h0, 8'h00, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule